// File: doc/BRIEF.md
# Keyed Configuration Port with Banked Device Registers

This block gives software a way to set up the logical devices inside a multi-function peripheral controller over an 8-bit I/O bus. It decodes two bus addresses: an index port and a data port. Out of reset the block is sealed. Software opens it by writing a fixed entry key to the index port twice in a row. While it is open, a write to the index port chooses a register, and the data port reads or writes that register. A single exit key seals the block again.

Registers below index 0x30 are shared by all devices. They are the logical-device selector at 0x07 and a small set of general scratch bytes starting at 0x20. Registers from 0x30 upward are banked: the device whose number is in the selector is the one that sees reads and writes there. Each device bank has an enable bit, a set of base-address bytes, an interrupt number and type, two DMA channel selects and a few option bytes. Each device's enable bit is brought out as a pin.

The key detector is a three-state machine. ST_LOCKED is the sealed state. Writing 0x87 to the index port moves it to ST_KEY_HALF, and any other index byte keeps it in ST_LOCKED. From ST_KEY_HALF, a second 0x87 moves it to ST_OPEN, and any other index byte sends it back to ST_LOCKED. From ST_OPEN, writing 0xAA returns it to ST_LOCKED, and any other byte becomes the register index while the machine stays in ST_OPEN. Accesses to the data port never move the machine.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the block is in ST_LOCKED and index is 0x00. The device selector is 0 and every enable bit and `dev_active` pin is 0. In each bank the interrupt type reads 0x02 and both DMA selects read 0x04 (no DMA). All other stored registers read 0x00.
- R2: The block opens (`cfg_open` = 1) only after 0x87 has been written to the index port (address 0x370) on two index writes in a row. A single 0x87 leaves `cfg_open` at 0.
- R3: While the key is being entered, any index-port byte other than 0x87 returns the detector to ST_LOCKED. After the sequence 0x87, other, 0x87 the block is still closed.
- R4: While open, writing 0xAA to the index port closes the block and does not change the stored index.
- R5: While closed, data-port writes (address 0x371) change no register. Reads from either port return 0xFF.
- R6: While open, an index-port write of any byte other than 0xAA sets the index. An index-port read returns the current index, and a data-port read returns the indexed register. When `io_rd` is 0, `io_rdata` is 0xFF.
- R7: Register 0x07 holds the device selector. Indices 0x30 to 0xFF reach only the bank of the selected device, so a write to one bank leaves the other banks unchanged. Indices below 0x30 reach the same registers whatever the selector holds.
- R8: Bank register 0x30 bit 0 enables the selected device and drives its `dev_active` bit. Bits 7 to 1 read back as 0.
- R9: Bank registers 0x60 to 0x63 hold two 16-bit base addresses. The high byte is at the even index and the low byte at the odd index, and all four bytes read back as written.
- R10: Bank registers 0x70 (interrupt number), 0x71 (interrupt type), 0x74 (receive DMA) and 0x75 (transmit DMA) read back as written.
- R11: Bank registers 0xF0 to 0xF3 are option bytes that read back as written.
- R12: An index that maps to no register reads 0x00 and ignores writes. When the selector is 9 or higher, every banked index reads 0x00 and ignores writes, and no `dev_active` bit changes.
- R13: Global registers 0x20 to 0x2F are read/write scratch bytes shared across all selector values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Single-cycle write strobe |
| io_rd | input | 1 | Read strobe; read data is combinational |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data |
| cfg_open | output | 1 | High while the key detector is in ST_OPEN |
| dev_active | output | 9 | Enable bit of each logical device |

## Verification
The hardest case to reach is a half-entered key that is broken off. It is only visible as `cfg_open` staying low, and it leaves nothing behind to read, because every read returns 0xFF while the block is closed. The stimulus writes 0x87, then a different byte, then 0x87, and checks that the port is still closed. It then writes one more 0x87 and checks that exactly this last write opens the port, which shows the detector was sitting in ST_KEY_HALF. Writes made while closed are checked the same indirect way: the bench sets up a device's enable bit, exits, writes a clearing value to the data port, and confirms that `dev_active` has not moved. After reopening, it confirms that the index survived the exit.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED   = 2'd0,
        ST_KEY_HALF = 2'd1,
        ST_OPEN     = 2'd2
    } key_state_t;

    localparam logic [7:0] KEY_ENTER    = 8'h87;
    localparam logic [7:0] KEY_EXIT     = 8'hAA;

    localparam logic [7:0] IDX_LDN      = 8'h07;
    localparam logic [7:0] IDX_GLOB     = 8'h20;
    localparam logic [7:0] IDX_BANK_LO  = 8'h30;
    localparam logic [7:0] IDX_ACT      = 8'h30;
    localparam logic [7:0] IDX_BASE     = 8'h60;
    localparam logic [7:0] IDX_IRQ_NUM  = 8'h70;
    localparam logic [7:0] IDX_IRQ_TYPE = 8'h71;
    localparam logic [7:0] IDX_DMA_RX   = 8'h74;
    localparam logic [7:0] IDX_DMA_TX   = 8'h75;
    localparam logic [7:0] IDX_OPT      = 8'hF0;

    localparam logic [7:0] RST_IRQ_TYPE = 8'h02;
    localparam logic [7:0] DMA_NONE     = 8'h04;
    localparam logic [7:0] BUS_IDLE     = 8'hFF;

endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wbyte,
    output logic       unlocked,
    output key_state_t state
);

    key_state_t state_q;
    key_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (idx_wr) begin
            unique case (state_q)
                ST_LOCKED:   state_d = (wbyte == KEY_ENTER) ? ST_KEY_HALF : ST_LOCKED;
                ST_KEY_HALF: state_d = (wbyte == KEY_ENTER) ? ST_OPEN     : ST_LOCKED;
                ST_OPEN:     state_d = (wbyte == KEY_EXIT)  ? ST_LOCKED   : ST_OPEN;
                default:     state_d = ST_LOCKED;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_OPEN: unlocked = 1'b1;
            default: unlocked = 1'b0;
        endcase
    end

    assign state = state_q;

    assert_second_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_KEY_HALF && idx_wr && wbyte == KEY_ENTER) |=> unlocked);

    assert_single_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED) |=> !unlocked);

    assert_broken_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_KEY_HALF && idx_wr && wbyte != KEY_ENTER) |=> state_q == ST_LOCKED);

    assert_exit_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN && idx_wr && wbyte == KEY_EXIT) |=> !unlocked);

    assert_hold_no_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_wr |=> $stable(state_q));

endmodule

// File: rtl/sio_glob_regs.sv
module sio_glob_regs
    import sio_cfg_pkg::*;
#(
    parameter int NUM_GLOB = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    output logic [7:0] ldn,
    output logic [7:0] rdata
);

    logic [7:0] ldn_q;
    logic [7:0] scratch_q [NUM_GLOB];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ldn_q <= '0;
            for (int i = 0; i < NUM_GLOB; i++) scratch_q[i] <= '0;
        end else if (wr_en) begin
            if (idx == IDX_LDN) ldn_q <= wdata;
            for (int i = 0; i < NUM_GLOB; i++) begin
                if (idx == IDX_GLOB + 8'(i)) scratch_q[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (idx == IDX_LDN) rdata = ldn_q;
        for (int i = 0; i < NUM_GLOB; i++) begin
            if (idx == IDX_GLOB + 8'(i)) rdata = scratch_q[i];
        end
    end

    assign ldn = ldn_q;

    assert_ldn_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ldn_q));

endmodule

// File: rtl/sio_dev_bank.sv
module sio_dev_bank
    import sio_cfg_pkg::*;
#(
    parameter int NUM_BASE_BYTES = 4,
    parameter int NUM_OPT        = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       active
);

    logic       act_q;
    logic [7:0] base_q [NUM_BASE_BYTES];
    logic [7:0] opt_q  [NUM_OPT];
    logic [7:0] irq_num_q;
    logic [7:0] irq_type_q;
    logic [7:0] dma_rx_q;
    logic [7:0] dma_tx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q      <= 1'b0;
            irq_num_q  <= '0;
            irq_type_q <= RST_IRQ_TYPE;
            dma_rx_q   <= DMA_NONE;
            dma_tx_q   <= DMA_NONE;
            for (int i = 0; i < NUM_BASE_BYTES; i++) base_q[i] <= '0;
            for (int i = 0; i < NUM_OPT; i++)        opt_q[i]  <= '0;
        end else if (wr_en) begin
            if (idx == IDX_ACT)      act_q      <= wdata[0];
            if (idx == IDX_IRQ_NUM)  irq_num_q  <= wdata;
            if (idx == IDX_IRQ_TYPE) irq_type_q <= wdata;
            if (idx == IDX_DMA_RX)   dma_rx_q   <= wdata;
            if (idx == IDX_DMA_TX)   dma_tx_q   <= wdata;
            for (int i = 0; i < NUM_BASE_BYTES; i++) begin
                if (idx == IDX_BASE + 8'(i)) base_q[i] <= wdata;
            end
            for (int i = 0; i < NUM_OPT; i++) begin
                if (idx == IDX_OPT + 8'(i)) opt_q[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (idx == IDX_ACT)      rdata = {7'b0, act_q};
        if (idx == IDX_IRQ_NUM)  rdata = irq_num_q;
        if (idx == IDX_IRQ_TYPE) rdata = irq_type_q;
        if (idx == IDX_DMA_RX)   rdata = dma_rx_q;
        if (idx == IDX_DMA_TX)   rdata = dma_tx_q;
        for (int i = 0; i < NUM_BASE_BYTES; i++) begin
            if (idx == IDX_BASE + 8'(i)) rdata = base_q[i];
        end
        for (int i = 0; i < NUM_OPT; i++) begin
            if (idx == IDX_OPT + 8'(i)) rdata = opt_q[i];
        end
    end

    assign active = act_q;

    assert_bank_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(act_q) && $stable(irq_num_q) && $stable(dma_rx_q)));

    assert_act_only_bit0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_ACT) |=> (active == $past(wdata[0])));

    assert_active_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && idx == IDX_ACT) |=> $stable(active));

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int              ADDR_W         = 16,
    parameter logic [15:0]     INDEX_ADDR     = 16'h0370,
    parameter logic [15:0]     DATA_ADDR      = 16'h0371,
    parameter int              NUM_DEV        = 9,
    parameter int              NUM_GLOB       = 16,
    parameter int              NUM_BASE_BYTES = 4,
    parameter int              NUM_OPT        = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic               io_wr,
    input  logic               io_rd,
    input  logic [7:0]         io_wdata,
    output logic [7:0]         io_rdata,
    output logic               cfg_open,
    output logic [NUM_DEV-1:0] dev_active
);

    localparam logic [ADDR_W-1:0] IDX_PORT = ADDR_W'(INDEX_ADDR);
    localparam logic [ADDR_W-1:0] DAT_PORT = ADDR_W'(DATA_ADDR);

    key_state_t   key_state;
    logic         idx_hit, dat_hit;
    logic         idx_wr, dat_wr;
    logic         glob_wr;
    logic [7:0]   index_q;
    logic [7:0]   ldn;
    logic [7:0]   glob_rdata;
    logic [7:0]   bank_rdata [NUM_DEV];
    logic [7:0]   bank_or;
    logic [NUM_DEV-1:0] bank_sel;
    logic [NUM_DEV-1:0] bank_wr;
    logic         banked;

    assign idx_hit = (io_addr == IDX_PORT);
    assign dat_hit = (io_addr == DAT_PORT);
    assign idx_wr  = io_wr && idx_hit;
    assign dat_wr  = io_wr && dat_hit && cfg_open;
    assign banked  = (index_q >= IDX_BANK_LO);
    assign glob_wr = dat_wr && !banked;

    sio_key_fsm u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .wbyte    (io_wdata),
        .unlocked (cfg_open),
        .state    (key_state)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                          index_q <= '0;
        else if (key_state == ST_OPEN && idx_wr && io_wdata != KEY_EXIT) index_q <= io_wdata;
    end

    sio_glob_regs #(.NUM_GLOB(NUM_GLOB)) u_glob (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (glob_wr),
        .idx   (index_q),
        .wdata (io_wdata),
        .ldn   (ldn),
        .rdata (glob_rdata)
    );

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_bank
        assign bank_sel[d] = (ldn == 8'(d));
        assign bank_wr[d]  = dat_wr && banked && bank_sel[d];
        sio_dev_bank #(
            .NUM_BASE_BYTES (NUM_BASE_BYTES),
            .NUM_OPT        (NUM_OPT)
        ) u_dev (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (bank_wr[d]),
            .idx    (index_q),
            .wdata  (io_wdata),
            .rdata  (bank_rdata[d]),
            .active (dev_active[d])
        );
    end

    always_comb begin
        bank_or = '0;
        for (int d = 0; d < NUM_DEV; d++) begin
            bank_or = bank_or | (bank_rdata[d] & {8{bank_sel[d]}});
        end
    end

    always_comb begin
        io_rdata = BUS_IDLE;
        if (io_rd && cfg_open) begin
            if (idx_hit)      io_rdata = index_q;
            else if (dat_hit) io_rdata = banked ? bank_or : glob_rdata;
        end
    end

    assert_locked_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && io_rd) |-> io_rdata == BUS_IDLE);

    assert_one_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_wr));

    assert_locked_no_bank_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |=> $stable(dev_active));

    assert_exit_keeps_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr && io_wdata == KEY_EXIT) |=> $stable(index_q));

endmodule

// File: tb/sio_cfg_port_test.sv
`timescale 1ns/1ps
module sio_cfg_port_test;

    localparam logic [15:0] IDXP = 16'h0370;
    localparam logic [15:0] DATP = 16'h0371;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        cfg_open;
    logic [8:0]  dev_active;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #10 clk = ~clk;

    sio_cfg_port uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_addr    (io_addr),
        .io_wr      (io_wr),
        .io_rd      (io_rd),
        .io_wdata   (io_wdata),
        .io_rdata   (io_rdata),
        .cfg_open   (cfg_open),
        .dev_active (dev_active)
    );

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic set_reg(input logic [7:0] idx, input logic [7:0] d);
        io_write(IDXP, idx);
        io_write(DATP, d);
    endtask

    // driver: queue expectation then issue the read
    task automatic rd_exp(input logic [15:0] a, input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic reg_exp(input logic [7:0] idx, input logic [7:0] e, input string tag);
        io_write(IDXP, idx);
        rd_exp(DATP, e, tag);
    endtask

    task automatic check(input logic [15:0] act, input logic [15:0] e, input string tag);
        compared++;
        if (act !== e) begin
            mismatched++;
            $display("FAIL %s: got %0h expected %0h", tag, act, e);
        end
    endtask

    // monitor: compare mid low phase
    always @(negedge clk) begin
        #5;
        if (io_rd && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            compared++;
            if (io_rdata !== e) begin
                mismatched++;
                $display("FAIL %s: got %02h expected %02h", t, io_rdata, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check(16'(cfg_open), 16'h0, "R1 cfg_open after reset");
        check(16'(dev_active), 16'h0, "R1 dev_active after reset");
        // R5: closed reads
        rd_exp(DATP, 8'hFF, "R5 closed data read");
        rd_exp(IDXP, 8'hFF, "R5 closed index read");
        // R6: idle bus value
        @(negedge clk); io_addr = DATP; #5;
        check(16'(io_rdata), 16'hFF, "R6 no read strobe");

        // R3: broken key
        io_write(IDXP, 8'h87);
        check(16'(cfg_open), 16'h0, "R2 single key stays closed");
        io_write(IDXP, 8'h12);
        io_write(IDXP, 8'h87);
        check(16'(cfg_open), 16'h0, "R3 broken key stays closed");
        io_write(IDXP, 8'h87);
        check(16'(cfg_open), 16'h1, "R2 double key opens");

        // R6 / R12 / R1
        rd_exp(IDXP, 8'h00, "R6 index after open");
        rd_exp(DATP, 8'h00, "R12 unmapped index 0");
        reg_exp(8'h07, 8'h00, "R1 selector reset");
        reg_exp(8'h30, 8'h00, "R1 enable reset");
        reg_exp(8'h71, 8'h02, "R1 irq type reset");
        reg_exp(8'h74, 8'h04, "R1 rx dma reset");
        reg_exp(8'h75, 8'h04, "R1 tx dma reset");

        // R8
        set_reg(8'h30, 8'hFF);
        rd_exp(DATP, 8'h01, "R8 enable reads bit0 only");
        check(16'(dev_active), 16'h001, "R8 dev0 active");

        // R7, R9, R10, R11 on device 2
        set_reg(8'h07, 8'h02);
        set_reg(8'h60, 8'h03);
        set_reg(8'h61, 8'h38);
        set_reg(8'h62, 8'h01);
        set_reg(8'h63, 8'h80);
        set_reg(8'h70, 8'h0A);
        set_reg(8'h71, 8'h00);
        set_reg(8'h74, 8'h01);
        set_reg(8'h75, 8'h03);
        set_reg(8'hF1, 8'h5A);
        set_reg(8'hF3, 8'hC3);
        set_reg(8'h30, 8'h01);
        check(16'(dev_active), 16'h005, "R8 dev2 active");
        reg_exp(8'h07, 8'h02, "R7 selector readback");
        reg_exp(8'h60, 8'h03, "R9 base0 high");
        reg_exp(8'h61, 8'h38, "R9 base0 low");
        reg_exp(8'h62, 8'h01, "R9 base1 high");
        reg_exp(8'h63, 8'h80, "R9 base1 low");
        reg_exp(8'h70, 8'h0A, "R10 irq number");
        reg_exp(8'h71, 8'h00, "R10 irq type");
        reg_exp(8'h74, 8'h01, "R10 rx dma");
        reg_exp(8'h75, 8'h03, "R10 tx dma");
        reg_exp(8'hF1, 8'h5A, "R11 option 1");
        reg_exp(8'hF3, 8'hC3, "R11 option 3");
        reg_exp(8'hF0, 8'h00, "R11 option 0 untouched");

        // R7 isolation
        set_reg(8'h07, 8'h00);
        reg_exp(8'h60, 8'h00, "R7 dev0 base untouched");
        reg_exp(8'h70, 8'h00, "R7 dev0 irq untouched");
        reg_exp(8'h30, 8'h01, "R7 dev0 enable kept");

        // R13 global scratch shared
        set_reg(8'h20, 8'h3C);
        set_reg(8'h2F, 8'hA5);
        set_reg(8'h07, 8'h02);
        reg_exp(8'h20, 8'h3C, "R13 scratch first");
        reg_exp(8'h2F, 8'hA5, "R13 scratch last");

        // R12 unmapped and out-of-range selector
        set_reg(8'h65, 8'h77);
        rd_exp(DATP, 8'h00, "R12 unmapped bank index");
        reg_exp(8'hF4, 8'h00, "R12 past options");
        set_reg(8'h07, 8'h0C);
        set_reg(8'h30, 8'h01);
        check(16'(dev_active), 16'h005, "R12 bad selector no enable");
        rd_exp(DATP, 8'h00, "R12 bad selector reads zero");
        reg_exp(8'h71, 8'h00, "R12 bad selector irq type");

        // R4 exit, R5 closed writes
        set_reg(8'h07, 8'h02);
        io_write(IDXP, 8'h30);
        io_write(IDXP, 8'hAA);
        check(16'(cfg_open), 16'h0, "R4 exit closes");
        rd_exp(DATP, 8'hFF, "R5 read after exit");
        io_write(DATP, 8'h00);
        check(16'(dev_active), 16'h005, "R5 closed write ignored");
        io_write(IDXP, 8'h87);
        io_write(IDXP, 8'h87);
        check(16'(cfg_open), 16'h1, "R2 reopen");
        rd_exp(IDXP, 8'h30, "R4 index kept across exit");
        rd_exp(DATP, 8'h01, "R5 dev2 enable intact");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule